// File: doc/BRIEF.md
# Byte-Wide Call/Return Stack Sequencer

This block executes the stack-related control transfers of a small 8-bit processor: direct subroutine call, call through a page-zero jump table, return, return from interrupt, and save/restore of either a 16-bit register pair or the 8-bit status byte. It holds the 16-bit stack pointer. Each operation is carried out as a fixed sequence of single-byte reads and writes on one byte-wide data memory port. The stack grows downward, and of any 16-bit value the high byte sits at the higher address.

The surrounding core presents a decoded operation with `start_i` while the sequencer is idle. With it come the operands the operation needs: the call target, the table index, the return address, the register pair or the status byte. The core then waits for `done_o`. In that cycle the new program counter, register pair or status byte can be read from the result outputs. The stack pointer takes its new value on the edge that closes the `done_o` cycle. The memory is assumed to return read data one clock after the address is presented.

Top module: `stack_seq_top`

## Requirements
- R1: After reset `sp_o` equals parameter `SP_INIT`, `busy_o` and `done_o` are low, and `mem_we_o` is never high while the sequencer is idle.
- R2: Direct call (op code 0) writes the high byte of `ret_addr_i` to SP-1 and the low byte to SP-2. It sets `pc_o` to `target_i` and lowers SP by 2.
- R3: Table call (op code 1) reads the new PC low byte from {8'h00, idx} and the high byte from {8'h00, idx+1}, where idx+1 wraps inside page zero. It pushes the return address exactly as a direct call does and lowers SP by 2.
- R4: Return (op code 2) loads the PC high byte from SP+1 and the low byte from SP, then raises SP by 2.
- R5: Interrupt return (op code 3) loads the PC as a return does, loads `st_o` from SP+2, and raises SP by 3.
- R6: Status push (op code 4) writes `st_i` to SP-1 and lowers SP by 1. Status pop (op code 6) loads `st_o` from SP and raises SP by 1.
- R7: Pair push (op code 5) writes the high byte of `pair_i` to SP-1 and the low byte to SP-2. Pair pop (op code 7) loads the high byte of `pair_o` from SP+1 and the low byte from SP. SP moves by 2 in both.
- R8: Counting the cycle in which `start_i` is accepted as cycle 1, `done_o` is high for exactly one cycle, cycle N. N is 6 for call, 8 for table call, 6 for return, 8 for interrupt return, 2 for status push, 4 for pair push, 4 for status pop and 6 for pair pop.
- R9: Each operation performs exactly its own number of byte writes, one per clock at most: 2 for call, table call and pair push, 1 for status push, 0 for the others.
- R10: `start_i` raised while busy is ignored. It changes neither SP, the memory, the results, nor the number of `done_o` pulses.
- R11: All stack pointer arithmetic, including the SP+1 and SP+2 addresses, wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin an operation; taken only when idle |
| op_i | input | 3 | Operation code (see requirements) |
| target_i | input | 16 | Direct call target address |
| tidx_i | input | 8 | Page-zero table index for a table call |
| ret_addr_i | input | 16 | Return address to push on a call |
| pair_i | input | 16 | Register pair value to push |
| st_i | input | 8 | Status byte to push |
| mem_addr_o | output | 16 | Data memory byte address |
| mem_wdata_o | output | 8 | Data memory write byte |
| mem_we_o | output | 1 | Data memory write enable |
| mem_rdata_i | input | 8 | Data memory read byte, valid one clock after the address |
| pc_o | output | 16 | New program counter |
| pair_o | output | 16 | Restored register pair |
| st_o | output | 8 | Restored status byte |
| sp_o | output | 16 | Current stack pointer |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | Final cycle of an operation |

## Verification
On every cycle the assertions check four things. Writes never happen while idle. The done pulse lasts exactly one cycle, and it falls on the last cycle of the latency belonging to the accepted operation. The stack pointer moves only at the edge that closes a done cycle. A direct call's target appears on the PC output right after acceptance. Only the directed scenarios can show the byte placement on the stack, the page-zero table fetch with its index wrap, the restored PC, pair and status values, the wrap of SP across address zero, and that a request during a busy operation is ignored.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int STEP_W = 3;
    localparam int OFF_W  = 3;

    typedef enum logic [2:0] {
        OP_CALL    = 3'd0,
        OP_TCALL   = 3'd1,
        OP_RET     = 3'd2,
        OP_RETI    = 3'd3,
        OP_PUSH_ST = 3'd4,
        OP_PUSH_PR = 3'd5,
        OP_POP_ST  = 3'd6,
        OP_POP_PR  = 3'd7
    } seq_op_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        AB_SP    = 2'd0,
        AB_TBL_L = 2'd1,
        AB_TBL_H = 2'd2
    } addr_base_e;

    typedef enum logic [2:0] {
        WB_RET_HI  = 3'd0,
        WB_RET_LO  = 3'd1,
        WB_ST      = 3'd2,
        WB_PAIR_HI = 3'd3,
        WB_PAIR_LO = 3'd4
    } wbyte_e;

    typedef enum logic [2:0] {
        DST_NONE    = 3'd0,
        DST_PC_LO   = 3'd1,
        DST_PC_HI   = 3'd2,
        DST_PAIR_LO = 3'd3,
        DST_PAIR_HI = 3'd4,
        DST_ST      = 3'd5
    } dest_e;

    typedef struct packed {
        acc_kind_e               kind;
        addr_base_e              base;
        logic signed [OFF_W-1:0] off;
        wbyte_e                  wsel;
        dest_e                   dst;
    } acc_plan_t;

    // Step index on which done is raised (latency minus one).
    function automatic logic [STEP_W-1:0] op_last_step(seq_op_e op);
        case (op)
            OP_CALL:    return 3'd5;
            OP_TCALL:   return 3'd7;
            OP_RET:     return 3'd5;
            OP_RETI:    return 3'd7;
            OP_PUSH_ST: return 3'd1;
            OP_PUSH_PR: return 3'd3;
            OP_POP_ST:  return 3'd3;
            default:    return 3'd5;
        endcase
    endfunction

    // Signed change applied to SP when the operation finishes.
    function automatic logic signed [OFF_W-1:0] sp_adjust(seq_op_e op);
        case (op)
            OP_CALL, OP_TCALL, OP_PUSH_PR: return -3'sd2;
            OP_RET, OP_POP_PR:             return 3'sd2;
            OP_RETI:                       return 3'sd3;
            OP_PUSH_ST:                    return -3'sd1;
            default:                       return 3'sd1;
        endcase
    endfunction

    function automatic acc_plan_t no_acc();
        return '{kind: ACC_IDLE, base: AB_SP, off: 3'sd0, wsel: WB_ST, dst: DST_NONE};
    endfunction

    function automatic acc_plan_t wr_sp(logic signed [OFF_W-1:0] off, wbyte_e sel);
        return '{kind: ACC_WRITE, base: AB_SP, off: off, wsel: sel, dst: DST_NONE};
    endfunction

    function automatic acc_plan_t rd_at(addr_base_e base, logic signed [OFF_W-1:0] off,
                                        dest_e dst);
        return '{kind: ACC_READ, base: base, off: off, wsel: WB_ST, dst: dst};
    endfunction

    // Memory access schedule: one byte per step, steps counted from 1.
    function automatic acc_plan_t step_plan(seq_op_e op, logic [STEP_W-1:0] step);
        acc_plan_t p;
        p = no_acc();
        case (op)
            OP_CALL: begin
                if (step == 3'd1)      p = wr_sp(-3'sd1, WB_RET_HI);
                else if (step == 3'd2) p = wr_sp(-3'sd2, WB_RET_LO);
            end
            OP_TCALL: begin
                if (step == 3'd1)      p = rd_at(AB_TBL_L, 3'sd0, DST_PC_LO);
                else if (step == 3'd2) p = rd_at(AB_TBL_H, 3'sd0, DST_PC_HI);
                else if (step == 3'd3) p = wr_sp(-3'sd1, WB_RET_HI);
                else if (step == 3'd4) p = wr_sp(-3'sd2, WB_RET_LO);
            end
            OP_RET, OP_RETI: begin
                if (step == 3'd1)      p = rd_at(AB_SP, 3'sd1, DST_PC_HI);
                else if (step == 3'd2) p = rd_at(AB_SP, 3'sd0, DST_PC_LO);
                else if (step == 3'd3 && op == OP_RETI)
                                       p = rd_at(AB_SP, 3'sd2, DST_ST);
            end
            OP_PUSH_ST: begin
                if (step == 3'd1)      p = wr_sp(-3'sd1, WB_ST);
            end
            OP_PUSH_PR: begin
                if (step == 3'd1)      p = wr_sp(-3'sd1, WB_PAIR_HI);
                else if (step == 3'd2) p = wr_sp(-3'sd2, WB_PAIR_LO);
            end
            OP_POP_ST: begin
                if (step == 3'd1)      p = rd_at(AB_SP, 3'sd0, DST_ST);
            end
            default: begin
                if (step == 3'd1)      p = rd_at(AB_SP, 3'sd1, DST_PAIR_HI);
                else if (step == 3'd2) p = rd_at(AB_SP, 3'sd0, DST_PAIR_LO);
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
    import stack_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  seq_op_e           op_in,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic [STEP_W-1:0] step,
    output seq_op_e           op_q
);

    logic busy_q;
    logic [STEP_W-1:0] step_q;

    assign accept = start && !busy_q;
    assign busy   = busy_q;
    assign step   = step_q;
    assign done   = busy_q && (step_q == op_last_step(op_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            step_q <= '0;
            op_q   <= OP_CALL;
        end else if (accept) begin
            busy_q <= 1'b1;
            step_q <= STEP_W'(1);
            op_q   <= op_in;
        end else if (done) begin
            busy_q <= 1'b0;
            step_q <= '0;
        end else if (busy_q) begin
            step_q <= step_q + STEP_W'(1);
        end
    end

endmodule

// File: rtl/stack_seq_agu.sv
module stack_seq_agu
    import stack_seq_pkg::*;
(
    input  logic                    busy,
    input  acc_kind_e               kind,
    input  addr_base_e              base,
    input  logic signed [OFF_W-1:0] off,
    input  wbyte_e                  wsel,
    input  logic [ADDR_W-1:0]       sp,
    input  logic [BYTE_W-1:0]       idx,
    input  logic [ADDR_W-1:0]       ret_addr,
    input  logic [2*BYTE_W-1:0]     pair,
    input  logic [BYTE_W-1:0]       st,
    output logic [ADDR_W-1:0]       addr,
    output logic [BYTE_W-1:0]       wdata,
    output logic                    we
);

    localparam int PAD_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] off_ext;
    logic [BYTE_W-1:0] idx_next;

    assign off_ext  = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
    assign idx_next = idx + BYTE_W'(1);

    always_comb begin
        case (base)
            AB_TBL_L: addr = {{PAD_W{1'b0}}, idx};
            AB_TBL_H: addr = {{PAD_W{1'b0}}, idx_next};
            default:  addr = sp + off_ext;
        endcase
    end

    always_comb begin
        case (wsel)
            WB_RET_HI:  wdata = ret_addr[ADDR_W-1 -: BYTE_W];
            WB_RET_LO:  wdata = ret_addr[BYTE_W-1:0];
            WB_PAIR_HI: wdata = pair[2*BYTE_W-1 -: BYTE_W];
            WB_PAIR_LO: wdata = pair[BYTE_W-1:0];
            default:    wdata = st;
        endcase
    end

    assign we = busy && (kind == ACC_WRITE);

endmodule

// File: rtl/stack_seq_capture.sv
module stack_seq_capture
    import stack_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_target,
    input  logic [ADDR_W-1:0]   target,
    input  logic                rd_issue,
    input  dest_e               rd_dst,
    input  logic [BYTE_W-1:0]   rdata,
    output logic [ADDR_W-1:0]   pc,
    output logic [2*BYTE_W-1:0] pair,
    output logic [BYTE_W-1:0]   st
);

    dest_e dst_q;

    always_ff @(posedge clk) begin
        if (rst) dst_q <= DST_NONE;
        else     dst_q <= rd_issue ? rd_dst : DST_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            pair <= '0;
            st   <= '0;
        end else begin
            if (load_target) pc <= target;
            case (dst_q)
                DST_PC_LO:   pc[BYTE_W-1:0]            <= rdata;
                DST_PC_HI:   pc[ADDR_W-1 -: BYTE_W]    <= rdata;
                DST_PAIR_LO: pair[BYTE_W-1:0]          <= rdata;
                DST_PAIR_HI: pair[2*BYTE_W-1 -: BYTE_W] <= rdata;
                DST_ST:      st                        <= rdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/stack_seq_top.sv
module stack_seq_top
    import stack_seq_pkg::*;
#(
    parameter logic [15:0] SP_INIT = 16'hFE00
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [2:0]  op_i,
    input  logic [15:0] target_i,
    input  logic [7:0]  tidx_i,
    input  logic [15:0] ret_addr_i,
    input  logic [15:0] pair_i,
    input  logic [7:0]  st_i,
    output logic [15:0] mem_addr_o,
    output logic [7:0]  mem_wdata_o,
    output logic        mem_we_o,
    input  logic [7:0]  mem_rdata_i,
    output logic [15:0] pc_o,
    output logic [15:0] pair_o,
    output logic [7:0]  st_o,
    output logic [15:0] sp_o,
    output logic        busy_o,
    output logic        done_o
);

    logic              accept;
    logic              busy;
    logic              done;
    logic [STEP_W-1:0] step;
    seq_op_e           op_q;
    seq_op_e           op_in;
    acc_plan_t         plan;

    logic [ADDR_W-1:0]   sp_q;
    logic [ADDR_W-1:0]   ret_q;
    logic [2*BYTE_W-1:0] pair_q;
    logic [BYTE_W-1:0]   st_q;
    logic [BYTE_W-1:0]   idx_q;
    logic signed [OFF_W-1:0] adj;

    assign op_in = seq_op_e'(op_i);

    stack_seq_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .op_in  (op_in),
        .accept (accept),
        .busy   (busy),
        .done   (done),
        .step   (step),
        .op_q   (op_q)
    );

    assign plan = step_plan(op_q, step);
    assign adj  = sp_adjust(op_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q   <= SP_INIT;
            ret_q  <= '0;
            pair_q <= '0;
            st_q   <= '0;
            idx_q  <= '0;
        end else begin
            if (accept) begin
                ret_q  <= ret_addr_i;
                pair_q <= pair_i;
                st_q   <= st_i;
                idx_q  <= tidx_i;
            end
            if (done) sp_q <= sp_q + {{(ADDR_W-OFF_W){adj[OFF_W-1]}}, adj};
        end
    end

    stack_seq_agu u_agu (
        .busy     (busy),
        .kind     (plan.kind),
        .base     (plan.base),
        .off      (plan.off),
        .wsel     (plan.wsel),
        .sp       (sp_q),
        .idx      (idx_q),
        .ret_addr (ret_q),
        .pair     (pair_q),
        .st       (st_q),
        .addr     (mem_addr_o),
        .wdata    (mem_wdata_o),
        .we       (mem_we_o)
    );

    stack_seq_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .load_target (accept && (op_in == OP_CALL)),
        .target      (target_i),
        .rd_issue    (busy && (plan.kind == ACC_READ)),
        .rd_dst      (plan.dst),
        .rdata       (mem_rdata_i),
        .pc          (pc_o),
        .pair        (pair_o),
        .st          (st_o)
    );

    assign sp_o   = sp_q;
    assign busy_o = busy;
    assign done_o = done;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk
    import stack_seq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic [2:0]  op_i,
    input logic [15:0] target_i,
    input logic        mem_we_o,
    input logic [15:0] pc_o,
    input logic [15:0] sp_o,
    input logic        busy_o,
    input logic        done_o
);

    logic [STEP_W-1:0] cyc_q;
    seq_op_e           op_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q   <= '0;
            op_seen <= OP_CALL;
        end else if (start_i && !busy_o) begin
            cyc_q   <= STEP_W'(1);
            op_seen <= seq_op_e'(op_i);
        end else if (busy_o) begin
            cyc_q <= cyc_q + STEP_W'(1);
        end
    end

    a_r1_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_we_o);

    a_r8_done_while_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cyc_q == op_last_step(op_seen)));

    a_r10_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    a_r11_sp_moves_on_done: assert property (@(posedge clk) disable iff (rst)
        !done_o |=> $stable(sp_o));

    a_r2_pc_target: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && op_i == 3'd0) |=> (pc_o == $past(target_i)));

endmodule

bind stack_seq_top stack_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .op_i     (op_i),
    .target_i (target_i),
    .mem_we_o (mem_we_o),
    .pc_o     (pc_o),
    .sp_o     (sp_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/stack_seq_top_tb_top.sv
module stack_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [15:0] target_i = '0;
    logic [7:0]  tidx_i = '0;
    logic [15:0] ret_addr_i = '0;
    logic [15:0] pair_i = '0;
    logic [7:0]  st_i = '0;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_we_o;
    logic [7:0]  mem_rdata_i;
    logic [15:0] pc_o;
    logic [15:0] pair_o;
    logic [7:0]  st_o;
    logic [15:0] sp_o;
    logic        busy_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_count = 0;
    int done_count = 0;

    always #10 clk = ~clk;

    stack_seq_top #(.SP_INIT(16'h0001)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .target_i(target_i), .tidx_i(tidx_i), .ret_addr_i(ret_addr_i),
        .pair_i(pair_i), .st_i(st_i), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
        .mem_rdata_i(mem_rdata_i), .pc_o(pc_o), .pair_o(pair_o),
        .st_o(st_o), .sp_o(sp_o), .busy_o(busy_o), .done_o(done_o)
    );

    // Byte memory, 1024 locations aliased by the low address bits.
    logic [7:0] mem [0:1023];
    logic       pre_we = 1'b0;
    logic [9:0] pre_addr = '0;
    logic [7:0] pre_data = '0;

    always @(posedge clk) begin
        if (pre_we)        mem[pre_addr] <= pre_data;
        else if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;
        mem_rdata_i <= mem[mem_addr_o[9:0]];
        if (mem_we_o) wr_count <= wr_count + 1;
        if (done_o)   done_count <= done_count + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a[9:0]; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    function automatic logic [7:0] peek(input logic [15:0] a);
        return mem[a[9:0]];
    endfunction

    // Issues one operation and checks its latency and single-cycle done.
    task automatic run_op(input logic [2:0] op, input int lat, input int writes,
                          input string req);
        int n;
        int w0;
        w0 = wr_count;
        @(negedge clk);
        op_i = op; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 2;
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({req, " R8 latency"}, n, lat);
        @(negedge clk);
        chk({req, " R8 single done"}, done_o, 0);
        chk({req, " R9 write count"}, wr_count - w0, writes);
    endtask

    task automatic t_reset();
        chk("R1 sp init", sp_o, 16'h0001);
        chk("R1 busy low", busy_o, 0);
        chk("R1 done low", done_o, 0);
        chk("R1 no write", mem_we_o, 0);
    endtask

    task automatic t_call();
        target_i = 16'h1234; ret_addr_i = 16'hABCD;
        run_op(3'd0, 6, 2, "R2 call");
        chk("R2 pc", pc_o, 16'h1234);
        chk("R2 hi at SP-1 R11", peek(16'h0000), 8'hAB);
        chk("R2 lo at SP-2 R11", peek(16'hFFFF), 8'hCD);
        chk("R2 R11 sp wrap down", sp_o, 16'hFFFF);
    endtask

    task automatic t_ret();
        target_i = 16'h0000;
        run_op(3'd2, 6, 0, "R4 ret");
        chk("R4 pc", pc_o, 16'hABCD);
        chk("R4 R11 sp wrap up", sp_o, 16'h0001);
    endtask

    task automatic t_pair();
        pair_i = 16'h5AA5;
        run_op(3'd5, 4, 2, "R7 push pair");
        chk("R7 hi at SP-1", peek(16'h0000), 8'h5A);
        chk("R7 lo at SP-2", peek(16'hFFFF), 8'hA5);
        chk("R7 sp after push", sp_o, 16'hFFFF);
    endtask

    task automatic t_status();
        st_i = 8'h3C;
        run_op(3'd4, 2, 1, "R6 push status");
        chk("R6 byte at SP-1", peek(16'hFFFE), 8'h3C);
        chk("R6 sp after push", sp_o, 16'hFFFE);
        st_i = 8'h00;
        run_op(3'd6, 4, 0, "R6 pop status");
        chk("R6 popped status", st_o, 8'h3C);
        chk("R6 sp after pop", sp_o, 16'hFFFF);
    endtask

    task automatic t_pop_pair();
        pair_i = 16'h0000;
        run_op(3'd7, 6, 0, "R7 pop pair");
        chk("R7 popped pair", pair_o, 16'h5AA5);
        chk("R7 sp after pop", sp_o, 16'h0001);
    endtask

    task automatic t_table_call();
        poke(16'h0040, 8'h78);
        poke(16'h0041, 8'h56);
        tidx_i = 8'h40; ret_addr_i = 16'h2468;
        run_op(3'd1, 8, 2, "R3 table call");
        chk("R3 pc from table", pc_o, 16'h5678);
        chk("R3 ret hi", peek(16'h0000), 8'h24);
        chk("R3 ret lo", peek(16'hFFFF), 8'h68);
        chk("R3 sp", sp_o, 16'hFFFF);
    endtask

    task automatic t_reti();
        poke(16'h0001, 8'h9E);
        run_op(3'd3, 8, 0, "R5 reti");
        chk("R5 pc", pc_o, 16'h2468);
        chk("R5 status from SP+2", st_o, 8'h9E);
        chk("R5 sp plus 3", sp_o, 16'h0002);
    endtask

    task automatic t_table_wrap();
        poke(16'h00FF, 8'h11);
        poke(16'h0000, 8'h22);
        tidx_i = 8'hFF; ret_addr_i = 16'h0F0E;
        run_op(3'd1, 8, 2, "R3 index wrap");
        chk("R3 pc with idx+1 wrap", pc_o, 16'h2211);
        chk("R3 ret hi wrap case", peek(16'h0001), 8'h0F);
        chk("R3 sp wrap case", sp_o, 16'h0000);
    endtask

    task automatic t_busy_ignore();
        int w0;
        int d0;
        w0 = wr_count;
        d0 = done_count;
        target_i = 16'h0BEE; ret_addr_i = 16'h7777;
        @(negedge clk);
        op_i = 3'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        op_i = 3'd4; st_i = 8'h55; target_i = 16'hDEAD; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
        chk("R10 one done", done_count - d0, 1);
        chk("R10 writes", wr_count - w0, 2);
        chk("R10 sp", sp_o, 16'hFFFE);
        chk("R10 pc", pc_o, 16'h0BEE);
        chk("R10 status untouched", st_o, 8'h9E);
        chk("R10 stack bytes", {peek(16'hFFFF), peek(16'hFFFE)}, 16'h7777);
        chk("R10 idle after", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_call();
        t_ret();
        t_pair();
        t_status();
        t_pop_pair();
        t_table_call();
        t_reti();
        t_table_wrap();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule